// File: doc/BRIEF.md
# Quad-Lane Framed Sample Serializer

This block takes one 32-bit word per sample period that holds four 8-bit converter samples, and sends each sample on its own serial lane. It runs from a single fast clock at four times the sample rate. A one-in-four strobe from the surrounding logic marks each sample period. Each lane delivers two bits per fast cycle, standing in for a double-data-rate link. `lane_bits[2*i+1]` is the bit sent on the rising half of the bit clock and `lane_bits[2*i]` is the bit sent on the falling half. `frame_o` marks the first bit of every byte. `bclk_run` shows whether the bit clock is toggling.

Samples arrive on a valid/ready stream. `smp_ready` is high for at most one fast cycle in four, in the cycle where `smp_stb` is high and a byte may start on the next edge. The producer holds `smp_valid` and `smp_data` stable until it sees `smp_ready` with `smp_valid`. If no word is offered at a byte boundary, the last accepted word is sent again. Two per-byte controls are sampled at the byte start: output coding and a fixed alignment pattern. When `pll_unlock` is raised, the outputs freeze and any byte in flight is dropped. After relock, the bit clock starts again at once, and framing resumes on a later strobe.

Top module: `quad_adc_serializer`

## Requirements
- R1: Every lane sends its byte MSB first, two bits per fast cycle. The four cycles after a byte start carry bits [7:6], [5:4], [3:2] and [1:0]. In each pair, the higher bit goes in lane bit 2*i+1 (the rising half) and the lower bit in lane bit 2*i.
- R2: Input samples are offset binary. With `fmt_twos` high at the byte start, the sent byte has bit 7 inverted (two's complement). With it low, the sample is sent unchanged.
- R3: With `tpat_en` high at the byte start, every lane sends 8'b1100_0000 whatever the data. `frame_o` and `bclk_run` behave as in normal operation.
- R4: A byte starts on the edge that samples `smp_stb` high. `frame_o` is high for the first two fast cycles of the byte and low for the last two.
- R5: `smp_ready` is high only when `smp_stb` is high and `pll_unlock` is low. A word is taken only on `smp_valid && smp_ready`. Changing `smp_data` in the middle of a byte does not alter the byte being sent. A boundary with no valid word repeats the last accepted word (zero after reset).
- R6: On every edge that samples `pll_unlock` high, `lane_bits` keeps its value, `bclk_run` goes low, `frame_o` goes low, and `smp_ready` stays low.
- R7: A byte cut short by lock loss is never resumed. The first byte after relock carries a word accepted after relock.
- R8: `bclk_run` is high after every edge that samples `pll_unlock` low. Let L be the first such edge and E the edge where the first `frame_o` rise appears. E minus L is between 2 and 5 fast cycles, that is 0.5 to under 1.5 sample periods.
- R9: During reset, `lane_bits` is zero and `frame_o`, `bclk_run` and `smp_ready` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast clock, four times the sample rate |
| rst_n | input | 1 | Active-low synchronous reset |
| smp_stb | input | 1 | One-in-four sample-period strobe |
| smp_valid | input | 1 | Sample word offered |
| smp_ready | output | 1 | Sample word taken on this edge if valid |
| smp_data | input | 32 | Four offset-binary samples, lane i in bits [8i+7:8i] |
| fmt_twos | input | 1 | 1: two's complement output, 0: offset binary |
| tpat_en | input | 1 | Send the fixed alignment pattern on all lanes |
| pll_unlock | input | 1 | High while the bit-clock source is unlocked |
| lane_bits | output | 8 | Two bits per lane per fast cycle, rising-half bit high |
| frame_o | output | 1 | Byte frame marker |
| bclk_run | output | 1 | Bit clock is running |

## Verification
The bench goes after lock loss at every byte slot and on the strobe cycle itself. A design that resumed the abandoned byte, or that let the lanes move while frozen, would show a byte that does not match a freshly accepted word, or a lane change during the freeze. It also times each relock against the 2-to-5-cycle window; a design that arms framing too early or too late puts the first frame rise outside it. Data is changed every cycle and valid is dropped at random boundaries. A design that sampled mid-byte or cleared its held word would send corrupted or zero bytes. Coding and pattern modes are switched at random, including the all-ones and 0x80 samples, to catch a design that inverts the wrong bit or lets the pattern stop the frame marker.

// File: rtl/qser_pkg.sv
package qser_pkg;
  typedef enum logic {
    LINK_WAIT = 1'b0,
    LINK_RUN  = 1'b1
  } link_state_e;

  typedef struct packed {
    logic twos;
    logic tpat;
  } byte_mode_t;
endpackage

// File: rtl/qser_ctrl.sv
module qser_ctrl
  import qser_pkg::*;
#(
  parameter int SLOTS   = 4,
  parameter int ARM_CYC = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic smp_stb,
  input  logic pll_unlock,
  output logic byte_start,
  output logic byte_shift,
  output logic frame_o,
  output logic bclk_run
);
  localparam int SLOT_W = (SLOTS > 1) ? $clog2(SLOTS) : 1;
  localparam int HALF   = SLOTS / 2;
  localparam int WCNT_W = $clog2(ARM_CYC + 1);
  localparam logic [SLOT_W-1:0] SLOT_LAST = SLOT_W'(SLOTS - 1);
  localparam logic [WCNT_W-1:0] WCNT_ARM  = WCNT_W'(ARM_CYC);

  link_state_e       st_q;
  logic [SLOT_W-1:0] slot_q;
  logic [SLOT_W-1:0] slot_nxt;
  logic [WCNT_W-1:0] wcnt_q;
  logic              armed;

  assign armed      = (st_q == LINK_RUN) || (wcnt_q >= WCNT_ARM);
  assign byte_start = smp_stb && !pll_unlock && armed;
  assign byte_shift = (st_q == LINK_RUN) && !pll_unlock && !byte_start;
  assign slot_nxt   = (slot_q == SLOT_LAST) ? slot_q : slot_q + 1'b1;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q     <= LINK_WAIT;
      wcnt_q   <= '0;
      slot_q   <= '0;
      frame_o  <= 1'b0;
      bclk_run <= 1'b0;
    end else if (pll_unlock) begin
      st_q     <= LINK_WAIT;
      wcnt_q   <= '0;
      frame_o  <= 1'b0;
      bclk_run <= 1'b0;
    end else begin
      bclk_run <= 1'b1;
      if (wcnt_q != WCNT_ARM) wcnt_q <= wcnt_q + 1'b1;
      if (byte_start) begin
        st_q    <= LINK_RUN;
        slot_q  <= '0;
        frame_o <= 1'b1;
      end else if (st_q == LINK_RUN) begin
        slot_q  <= slot_nxt;
        frame_o <= (int'(slot_nxt) < HALF);
      end
    end
  end
endmodule

// File: rtl/qser_coder.sv
module qser_coder
  import qser_pkg::*;
#(
  parameter int W = 8
) (
  input  logic [W-1:0] raw,
  input  byte_mode_t   mode,
  output logic [W-1:0] coded
);
  localparam logic [W-1:0] ALIGN_PAT = {2'b11, {(W-2){1'b0}}};
  localparam logic [W-1:0] SIGN_BIT  = {1'b1, {(W-1){1'b0}}};

  always_comb begin
    if (mode.tpat)      coded = ALIGN_PAT;
    else if (mode.twos) coded = raw ^ SIGN_BIT;
    else                coded = raw;
  end
endmodule

// File: rtl/qser_lane.sv
module qser_lane #(
  parameter int W   = 8,
  parameter int BPC = 2
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           load,
  input  logic           shift,
  input  logic [W-1:0]   byte_in,
  output logic [BPC-1:0] pair_o
);
  logic [W-1:0] sreg_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sreg_q <= '0;
      pair_o <= '0;
    end else if (load) begin
      pair_o <= byte_in[W-1 -: BPC];
      sreg_q <= byte_in << BPC;
    end else if (shift) begin
      pair_o <= sreg_q[W-1 -: BPC];
      sreg_q <= sreg_q << BPC;
    end
  end
endmodule

// File: rtl/quad_adc_serializer.sv
module quad_adc_serializer
  import qser_pkg::*;
#(
  parameter int LANES  = 4,
  parameter int SAMP_W = 8,
  parameter int BPC    = 2
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    smp_stb,
  input  logic                    smp_valid,
  output logic                    smp_ready,
  input  logic [LANES*SAMP_W-1:0] smp_data,
  input  logic                    fmt_twos,
  input  logic                    tpat_en,
  input  logic                    pll_unlock,
  output logic [LANES*BPC-1:0]    lane_bits,
  output logic                    frame_o,
  output logic                    bclk_run
);
  localparam int SLOTS   = SAMP_W / BPC;
  localparam int ARM_CYC = SLOTS / 2;

  logic                    byte_start;
  logic                    byte_shift;
  logic [LANES*SAMP_W-1:0] held_q;
  logic [LANES*SAMP_W-1:0] word_sel;
  byte_mode_t              mode;

  qser_ctrl #(.SLOTS(SLOTS), .ARM_CYC(ARM_CYC)) ctrl_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .smp_stb    (smp_stb),
    .pll_unlock (pll_unlock),
    .byte_start (byte_start),
    .byte_shift (byte_shift),
    .frame_o    (frame_o),
    .bclk_run   (bclk_run)
  );

  assign smp_ready = byte_start;
  assign word_sel  = smp_valid ? smp_data : held_q;
  assign mode      = '{twos: fmt_twos, tpat: tpat_en};

  always_ff @(posedge clk) begin
    if (!rst_n)                       held_q <= '0;
    else if (byte_start && smp_valid) held_q <= smp_data;
  end

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [SAMP_W-1:0] coded;

    qser_coder #(.W(SAMP_W)) coder_i (
      .raw   (word_sel[g*SAMP_W +: SAMP_W]),
      .mode  (mode),
      .coded (coded)
    );

    qser_lane #(.W(SAMP_W), .BPC(BPC)) lane_i (
      .clk     (clk),
      .rst_n   (rst_n),
      .load    (byte_start),
      .shift   (byte_shift),
      .byte_in (coded),
      .pair_o  (lane_bits[g*BPC +: BPC])
    );
  end
endmodule

// File: rtl/qser_checker.sv
module qser_checker #(
  parameter int LB = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          smp_stb,
  input logic          smp_ready,
  input logic          pll_unlock,
  input logic [LB-1:0] lane_bits,
  input logic          frame_o,
  input logic          bclk_run
);
  assert_ready_gate_R5: assert property (@(posedge clk) disable iff (!rst_n)
    smp_ready |-> (smp_stb && !pll_unlock));

  assert_freeze_lanes_R6: assert property (@(posedge clk) disable iff (!rst_n)
    pll_unlock |=> $stable(lane_bits));

  assert_freeze_marks_R6: assert property (@(posedge clk) disable iff (!rst_n)
    pll_unlock |=> (!bclk_run && !frame_o));

  assert_bclk_restart_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !pll_unlock |=> bclk_run);

  assert_frame_on_strobe_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(frame_o) |-> $past(smp_stb));

  assert_frame_width_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_o && $past(frame_o)) |=> !frame_o);
endmodule

bind quad_adc_serializer qser_checker #(.LB(LANES*BPC)) chk_i (
  .clk        (clk),
  .rst_n      (rst_n),
  .smp_stb    (smp_stb),
  .smp_ready  (smp_ready),
  .pll_unlock (pll_unlock),
  .lane_bits  (lane_bits),
  .frame_o    (frame_o),
  .bclk_run   (bclk_run)
);

// File: tb/quad_adc_serializer_tb.sv
`timescale 1ns/1ps
module quad_adc_serializer_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        smp_stb = 1'b0;
  logic        smp_valid = 1'b0;
  logic        smp_ready;
  logic [31:0] smp_data = '0;
  logic        fmt_twos = 1'b0;
  logic        tpat_en = 1'b0;
  logic        pll_unlock = 1'b0;
  logic [7:0]  lane_bits;
  logic        frame_o;
  logic        bclk_run;

  always #5 clk = ~clk;

  quad_adc_serializer dut_i (
    .clk(clk), .rst_n(rst_n), .smp_stb(smp_stb), .smp_valid(smp_valid),
    .smp_ready(smp_ready), .smp_data(smp_data), .fmt_twos(fmt_twos),
    .tpat_en(tpat_en), .pll_unlock(pll_unlock), .lane_bits(lane_bits),
    .frame_o(frame_o), .bclk_run(bclk_run)
  );

  int checks = 0;
  int errors = 0;
  bit done = 0;

  int         phase = 0;
  bit         mon_on = 0;
  bit         cur_u = 0;
  int         cnt_low = 0;
  bit         need_first = 1;
  bit         pend_ok = 0;
  logic [7:0] pend [4];
  string      pend_tag = "R1";
  logic [7:0] held [4];
  logic [7:0] expb [4];
  string      exp_tag = "R1";
  bit         byte_act = 0;
  int         slot = 0;
  logic       prev_frame = 0;
  logic [7:0] prev_lanes = '0;

  function automatic logic [7:0] code_of(logic [7:0] d, logic tw, logic tp);
    if (tp) return 8'b1100_0000;
    return tw ? (d ^ 8'h80) : d;
  endfunction

  task automatic chk(bit ok, string req, string what, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic monitor();
    chk(bclk_run == !cur_u, cur_u ? "R6" : "R8", "bclk_run", bclk_run, !cur_u);
    if (cur_u) begin
      chk(lane_bits == prev_lanes, "R6", "lanes frozen", lane_bits, prev_lanes);
      chk(frame_o == 1'b0, "R6", "frame low while unlocked", frame_o, 0);
      byte_act = 0; pend_ok = 0; need_first = 1; cnt_low = 0;
    end else begin
      cnt_low++;
      if (frame_o && !prev_frame) begin
        if (need_first) begin
          chk(cnt_low >= 3 && cnt_low <= 6, "R8", "relock frame delay", cnt_low - 1, 2);
          chk(pend_ok, "R7", "first byte from fresh word", pend_ok, 1);
          need_first = 0;
        end else begin
          chk(pend_ok, "R4", "frame rise follows accepted boundary", pend_ok, 1);
        end
        for (int i = 0; i < 4; i++) expb[i] = pend[i];
        exp_tag = pend_tag;
        byte_act = 1; slot = 0; pend_ok = 0;
      end
      if (byte_act && slot < 4) begin
        for (int i = 0; i < 4; i++)
          chk(lane_bits[2*i +: 2] == expb[i][7-2*slot -: 2], exp_tag, "lane pair",
              lane_bits[2*i +: 2], expb[i][7-2*slot -: 2]);
        chk(frame_o == (slot < 2), "R4", "frame shape", frame_o, slot < 2);
        slot++;
      end
    end
    prev_frame = frame_o;
    prev_lanes = lane_bits;
  endtask

  task automatic step(logic v, logic [31:0] d, logic tw, logic tp, logic u);
    @(negedge clk);
    if (mon_on) monitor();
    smp_valid = v; smp_data = d; fmt_twos = tw; tpat_en = tp; pll_unlock = u;
    smp_stb = (phase == 3);
    phase = (phase + 1) % 4;
    cur_u = u;
    #1;
    if (smp_ready) begin
      chk(smp_stb && !u, "R5", "ready gating", smp_ready, 0);
      for (int i = 0; i < 4; i++) begin
        if (v) held[i] = d[8*i +: 8];
        pend[i] = code_of(held[i], tw, tp);
      end
      pend_tag = tp ? "R3" : (!v ? "R5" : (tw ? "R2" : "R1"));
      pend_ok = 1;
    end
    mon_on = 1;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    void'($urandom(32'd4242));
    for (int i = 0; i < 4; i++) held[i] = 8'h00;
    repeat (3) @(negedge clk);
    chk(lane_bits == 8'h00, "R9", "reset lanes", lane_bits, 0);
    chk(!frame_o && !bclk_run && !smp_ready, "R9", "reset marks",
        {frame_o, bclk_run, smp_ready}, 0);
    rst_n = 1'b1;
    // directed: coding corners, offset binary then two's complement
    repeat (8) step(1, 32'hFF80_7F00, 0, 0, 0);
    repeat (8) step(1, 32'hFF80_7F00, 1, 0, 0);
    // alignment pattern
    repeat (8) step(1, 32'h1234_5678, 0, 1, 0);
    // data changing every cycle, valid dropped: held word repeats
    for (int k = 0; k < 12; k++) step(k < 4, $urandom, 0, 0, 0);
    // lock loss mid-byte, then on various phases
    for (int p = 0; p < 4; p++) begin
      repeat (5 + p) step(1, $urandom, 1, 0, 0);
      repeat (3 + p) step(1, $urandom, 1, 0, 1);
      repeat (12) step(1, $urandom, 0, 0, 0);
    end
    // random
    for (int k = 0; k < 4000; k++) begin
      int r = $urandom_range(0, 99);
      step(($urandom_range(0, 3) != 0), $urandom,
           ($urandom_range(0, 1) == 1), (r < 8),
           ($urandom_range(0, 99) < 4));
    end
    repeat (12) step(1, $urandom, 0, 0, 0);
    finish_run();
  end
endmodule